// File: doc/BRIEF.md
# Statistics Tally Counter Dump Engine

This block keeps thirteen network traffic statistics counters, each bumped by its own one-cycle event strobe. On a host command it captures all of them in one cycle into a packed, little-endian 64-byte record and sends that record out as a stream of addressed write beats. The host writes a destination address with the dump command bit set. It then polls the command bit, which stays set until the last beat has been accepted.

A dump is only allowed while the receiver is enabled. A request made while the receiver is off is dropped, and the command bit never sets, so a polling host cannot hang. The snapshot is taken from registers. Events keep counting into the live counters while a dump is streaming out, and they appear in the next dump.

The write stream is valid/ready. `wr_valid` rises in the cycle after a dump is accepted. `wr_addr` and `wr_data` hold steady for as long as `wr_valid` is high and `wr_ready` is low. A beat is transferred at each rising clock edge where both are high. `BEAT_BYTES` must be a power of two that divides 64. With `wr_ready` held high, the whole record leaves in 64/`BEAT_BYTES` cycles.

Top module: `tally_dump_engine`

## Requirements
- R1: After reset every counter reads zero, `dump_pending` is 0 and `wr_valid` is 0, so the first dump emits an all-zero record.
- R2: Each cycle in which `ev_inc[i]` is 1 adds exactly one to counter i, and a counter whose strobe is 0 keeps its value. The strobe bits map as follows: 0 tx packets, 1 rx packets, 2 tx errors, 3 rx errors, 4 rx missed, 5 alignment errors, 6 single-collision tx, 7 multi-collision tx, 8 rx unicast, 9 rx broadcast, 10 rx multicast, 11 tx aborted, 12 tx underrun.
- R3: Each counter saturates at 2^min(field width, `CAP_BITS`) - 1 and never wraps.
- R4: The record is 64 bytes and every field is little-endian. The byte offsets and sizes are: strobe 0 at offset 0 (8 bytes), 1 at 8 (8), 2 at 16 (8), 3 at 24 (4), 4 at 28 (2), 5 at 30 (2), 6 at 32 (4), 7 at 36 (4), 8 at 40 (8), 9 at 48 (8), 10 at 56 (4), 11 at 60 (2), 12 at 62 (2).
- R5: A dump is accepted when `cmd_wr`, `cmd_dump` and `rx_enable` are all 1 while `dump_pending` is 0. `dump_pending` is 1 from the next cycle. The snapshot holds the counter values from before the strobes of that same cycle.
- R6: A dump emits 64/`BEAT_BYTES` beats in order. Beat k carries address `cmd_addr` + k*`BEAT_BYTES`, and its data byte j (bits 8j+7..8j) is record byte k*`BEAT_BYTES`+j.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R8: `dump_pending` stays 1 until the last beat is transferred and is 0 in the cycle after that transfer.
- R9: A dump request made while `rx_enable` is 0 is dropped: `dump_pending` stays 0 and no beat is emitted.
- R10: Strobes that arrive during a dump are counted in the live counters and appear in the next dump. They do not alter the record already in flight.
- R11: Host writes made while `dump_pending` is 1 are ignored. The dump in flight keeps its addresses, and no second dump follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_inc | input | 13 | Per-counter increment strobes (mapping in R2) |
| rx_enable | input | 1 | Receiver enabled status; dumps need it high |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_dump | input | 1 | Dump command bit written with `cmd_wr` |
| cmd_addr | input | ADDR_W | Destination byte address written with `cmd_wr` |
| dump_pending | output | 1 | Read-back of the dump command bit; high while a dump runs |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted by the sink |
| wr_addr | output | ADDR_W | Byte address of the current beat |
| wr_data | output | 8*BEAT_BYTES | Little-endian beat data |

## Verification
The bench builds the block with `CAP_BITS` = 6, `BEAT_BYTES` = 4 and `ADDR_W` = 32. With the cap at 6, every counter saturates at 63 after a few dozen strobes, which makes the no-wrap rule reachable in a short run. The 64-bit fields still sit in the record with their upper bytes at zero. Four-byte beats give a 16-beat dump. On odd vector rows the sink stalls on every third cycle, which exercises back-pressure holding and the rule that the pending bit clears only after the final transfer.

// File: rtl/tally_pkg.sv
package tally_pkg;

  localparam int unsigned NUM_FIELDS = 13;
  localparam int unsigned REC_BYTES  = 64;
  localparam int unsigned REC_BITS   = REC_BYTES * 8;

  // Strobe index of each counter; also its slot in the record.
  typedef enum int unsigned {
    EV_TX_PKT    = 0,
    EV_RX_PKT    = 1,
    EV_TX_ERR    = 2,
    EV_RX_ERR    = 3,
    EV_RX_MISS   = 4,
    EV_ALIGN     = 5,
    EV_COL_ONE   = 6,
    EV_COL_MULTI = 7,
    EV_RX_UNI    = 8,
    EV_RX_BCAST  = 9,
    EV_RX_MCAST  = 10,
    EV_TX_ABORT  = 11,
    EV_TX_UNDER  = 12
  } ev_idx_e;

  typedef int unsigned field_arr_t [NUM_FIELDS];

  // Bit width of each record field, in record order.
  localparam field_arr_t FIELD_BITS = '{64, 64, 64, 32, 16, 16, 32, 32, 64, 64, 32, 16, 16};

  // Bit position of the least significant bit of field idx in the record.
  function automatic int unsigned field_lsb(int unsigned idx);
    int unsigned sum;
    sum = 0;
    for (int unsigned i = 0; i < NUM_FIELDS; i++) begin
      if (i < idx) sum += FIELD_BITS[i];
    end
    return sum;
  endfunction

endpackage

// File: rtl/tally_counter.sv
module tally_counter #(
  parameter int unsigned W   = 32,
  parameter int unsigned CAP = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam int unsigned EFF = (CAP < W) ? CAP : W;

  logic [EFF-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (inc && (q != {EFF{1'b1}})) begin
      q <= q + 1'b1;
    end
  end

  assign value = W'(q);

  // Once at the ceiling, the count stays there.
  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q == {EFF{1'b1}}) |=> (q == {EFF{1'b1}}));

  // Without a strobe the count does not move.
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(q));

  // A strobe moves the count by at most one.
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> ((q == $past(q)) || (q == $past(q) + 1'b1)));

endmodule

// File: rtl/tally_streamer.sv
module tally_streamer #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned REC_BITS   = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic [REC_BITS-1:0]     record,
  output logic                    busy,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [8*BEAT_BYTES-1:0] wr_data
);
  localparam int unsigned BW    = 8 * BEAT_BYTES;
  localparam int unsigned BEATS = REC_BITS / BW;
  localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [REC_BITS-1:0] shreg;
  logic [ADDR_W-1:0]   addr_q;
  logic [IDX_W-1:0]    idx_q;
  logic                busy_q;
  logic                xfer;

  assign xfer = busy_q && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      addr_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start && !busy_q) begin
      shreg  <= record;
      addr_q <= start_addr;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (xfer) begin
      shreg  <= shreg >> BW;
      addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign wr_valid = busy_q;
  assign wr_addr  = addr_q;
  assign wr_data  = shreg[BW-1:0];

  // A stalled beat holds address and data.
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  // Consecutive beats of one dump are BEAT_BYTES apart.
  assert_addr_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (idx_q != LAST)) |=> (wr_addr == $past(wr_addr) + ADDR_W'(BEAT_BYTES)));

  // Busy drops only right after a transfer.
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(wr_valid && wr_ready));

endmodule

// File: rtl/tally_dump_engine.sv
module tally_dump_engine #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned CAP_BITS   = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [tally_pkg::NUM_FIELDS-1:0]  ev_inc,
  input  logic                              rx_enable,
  input  logic                              cmd_wr,
  input  logic                              cmd_dump,
  input  logic [ADDR_W-1:0]                 cmd_addr,
  output logic                              dump_pending,
  output logic                              wr_valid,
  input  logic                              wr_ready,
  output logic [ADDR_W-1:0]                 wr_addr,
  output logic [8*BEAT_BYTES-1:0]           wr_data
);
  import tally_pkg::*;

  logic [REC_BITS-1:0] live_rec;
  logic                busy;
  logic                start;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cnt
    localparam int unsigned FW  = FIELD_BITS[g];
    localparam int unsigned LSB = field_lsb(g);
    logic [FW-1:0] val;

    tally_counter #(.W(FW), .CAP(CAP_BITS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_inc[g]),
      .value (val)
    );

    assign live_rec[LSB +: FW] = val;
  end

  // Requests with the receiver off never set the command bit.
  assign start = cmd_wr && cmd_dump && rx_enable && !busy;

  tally_streamer #(
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .REC_BITS   (REC_BITS)
  ) u_stream (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (cmd_addr),
    .record     (live_rec),
    .busy       (busy),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  assign dump_pending = busy;

  // A request with the receiver off leaves the command bit clear.
  assert_rx_off_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_dump && !rx_enable && !dump_pending) |=> !dump_pending);

  // A qualified request sets the command bit.
  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_dump && rx_enable && !dump_pending) |=> dump_pending);

  // A host write during a dump cannot move the beat address.
  assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_pending && cmd_wr && !wr_ready) |=> $stable(wr_addr));

endmodule

// File: tb/tb_tally_dump_engine.sv
module tb_tally_dump_engine;
  localparam int AW    = 32;
  localparam int BB    = 4;
  localparam int CAP   = 6;
  localparam int NF    = 13;
  localparam int BEATS = 64 / BB;
  localparam longint MAXV = (64'd1 << CAP) - 1;
  localparam int NROWS = 6;

  // Stimulus rows: strobe mask, repeat count, stall mode, strobes during dump.
  localparam logic [12:0] T_EV  [NROWS] = '{13'h0000, 13'h0001, 13'h1fff, 13'h0a55, 13'h15aa, 13'h1fff};
  localparam int          T_N   [NROWS] = '{0, 3, 5, 7, 11, 70};
  localparam int          T_STL [NROWS] = '{0, 1, 0, 1, 0, 1};
  localparam logic [12:0] T_DUR [NROWS] = '{13'h0000, 13'h0000, 13'h0000, 13'h0000, 13'h1248, 13'h0000};

  // Field offsets and sizes in bytes, from R4.
  localparam int F_OFF [NF] = '{0, 8, 16, 24, 28, 30, 32, 36, 40, 48, 56, 60, 62};
  localparam int F_SZ  [NF] = '{8, 8, 8, 4, 2, 2, 4, 4, 8, 8, 4, 2, 2};

  logic          clk;
  logic          rst_n;
  logic [12:0]   ev_inc;
  logic          rx_enable;
  logic          cmd_wr;
  logic          cmd_dump;
  logic [AW-1:0] cmd_addr;
  logic          dump_pending;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [8*BB-1:0] wr_data;

  tally_dump_engine #(.ADDR_W(AW), .BEAT_BYTES(BB), .CAP_BITS(CAP)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_inc       (ev_inc),
    .rx_enable    (rx_enable),
    .cmd_wr       (cmd_wr),
    .cmd_dump     (cmd_dump),
    .cmd_addr     (cmd_addr),
    .dump_pending (dump_pending),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  longint model [NF];
  logic [7:0] exp_rec [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: inputs already driven at a falling edge.
  task automatic step();
    @(posedge clk);
    for (int i = 0; i < NF; i++) begin
      if (ev_inc[i] && model[i] < MAXV) model[i]++;
    end
    @(negedge clk);
  endtask

  task automatic build_exp();
    for (int f = 0; f < NF; f++) begin
      for (int j = 0; j < F_SZ[f]; j++) begin
        exp_rec[F_OFF[f] + j] = 8'((model[f] >> (8 * j)) & 64'hff);
      end
    end
  endtask

  task automatic run_dump(input logic [AW-1:0] base, input int stall, input logic [12:0] during,
                          input bit poke, input string lbl);
    int idx;
    int iter;
    bit held;
    bit rdy;
    logic [8*BB-1:0] hdata;
    logic [AW-1:0]   haddr;
    logic [8*BB-1:0] ew;
    build_exp();
    cmd_wr   = 1'b1;
    cmd_dump = 1'b1;
    cmd_addr = base;
    ev_inc   = during;
    wr_ready = 1'b0;
    step();
    cmd_wr = 1'b0;
    chk(dump_pending == 1'b1, "R5 pending after request", 64'(dump_pending), 64'd1);
    idx = 0;
    iter = 0;
    held = 1'b0;
    hdata = '0;
    haddr = '0;
    while (idx < BEATS && iter < 200) begin
      if (held) begin
        chk(wr_valid && wr_data == hdata && wr_addr == haddr, "R7 stall hold",
            64'(wr_data), 64'(hdata));
      end
      rdy = (stall == 0) ? 1'b1 : ((iter % 3) != 1);
      wr_ready = rdy;
      if (poke && iter == 2) begin
        cmd_wr   = 1'b1;
        cmd_dump = 1'b1;
        cmd_addr = base ^ 32'h5a5a_0000;
      end else begin
        cmd_wr = 1'b0;
      end
      held = 1'b0;
      chk(wr_valid, "R6 valid during dump", 64'(wr_valid), 64'd1);
      if (wr_valid && rdy) begin
        for (int j = 0; j < BB; j++) ew[8*j +: 8] = exp_rec[idx*BB + j];
        chk(wr_addr == base + AW'(idx * BB), lbl, 64'(wr_addr), 64'(base + AW'(idx * BB)));
        chk(wr_data == ew, lbl, 64'(wr_data), 64'(ew));
        idx++;
      end else if (wr_valid) begin
        held  = 1'b1;
        hdata = wr_data;
        haddr = wr_addr;
      end
      step();
      iter++;
      chk(dump_pending == (idx < BEATS), "R8 pending vs beats left",
          64'(dump_pending), 64'(idx < BEATS));
    end
    wr_ready = 1'b0;
    cmd_wr   = 1'b0;
    ev_inc   = '0;
  endtask

  initial begin
    for (int i = 0; i < NF; i++) model[i] = 0;
    rst_n     = 1'b0;
    ev_inc    = '0;
    rx_enable = 1'b1;
    cmd_wr    = 1'b0;
    cmd_dump  = 1'b0;
    cmd_addr  = '0;
    wr_ready  = 1'b0;
    repeat (3) @(negedge clk);
    chk(dump_pending == 1'b0, "R1 pending in reset", 64'(dump_pending), 64'd0);
    chk(wr_valid == 1'b0, "R1 valid in reset", 64'(wr_valid), 64'd0);
    rst_n = 1'b1;
    step();
    chk(dump_pending == 1'b0 && wr_valid == 1'b0, "R1 idle after reset",
        64'({dump_pending, wr_valid}), 64'd0);

    // Vector table walk.
    for (int r = 0; r < NROWS; r++) begin
      string lbl;
      case (r)
        0: lbl = "R1 zero record";
        1: lbl = "R2 single counter";
        2: lbl = "R6 beat layout";
        3: lbl = "R4 field packing";
        4: lbl = "R10 strobes during dump";
        default: lbl = "R3 saturation";
      endcase
      ev_inc = T_EV[r];
      for (int n = 0; n < T_N[r]; n++) step();
      ev_inc = '0;
      run_dump(32'h1000_0000 + AW'(r * 256), T_STL[r], T_DUR[r], 1'b0, lbl);
    end

    // R10: strobes counted during row 4 show up now; R3 still saturated.
    run_dump(32'h2000_0040, 0, 13'h0000, 1'b0, "R10 next dump");

    // R9: request with receiver off is dropped.
    rx_enable = 1'b0;
    cmd_wr    = 1'b1;
    cmd_dump  = 1'b1;
    cmd_addr  = 32'h3000_0000;
    wr_ready  = 1'b1;
    step();
    cmd_wr = 1'b0;
    chk(dump_pending == 1'b0, "R9 pending stays clear", 64'(dump_pending), 64'd0);
    for (int k = 0; k < 4; k++) begin
      chk(wr_valid == 1'b0, "R9 no beats", 64'(wr_valid), 64'd0);
      step();
    end
    wr_ready  = 1'b0;
    rx_enable = 1'b1;

    // R5 and R11: strobes in the request cycle are excluded; a poke mid-dump is ignored.
    for (int i = 0; i < NF; i++) model[i] = model[i];
    run_dump(32'h4000_0100, 1, 13'h0fff, 1'b1, "R11 write while pending");
    wr_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk(wr_valid == 1'b0 && dump_pending == 1'b0, "R11 no second dump",
          64'({dump_pending, wr_valid}), 64'd0);
      step();
    end
    wr_ready = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule